// File: doc/BRIEF.md
# Calendar Time Counter with Alarm

This block keeps wall-clock time for a chip. Seconds, minutes and hours are held as packed BCD bytes, and the day is a flat binary count that starts at zero. The day field is 15 bits wide by default. Each pulse on a one-second tick input moves the time forward by one second. Carries ripple from seconds to minutes, from minutes to hours and from hours to the day count. Counting runs only while the calendar is enabled.

A byte-wide register bus exposes the block. The bus carries an address, a write strobe, a read strobe and 8-bit data in each direction. Software can load the time, program an alarm on minute, hour and day, and choose which of those three fields take part in the match. A read-only busy bit tells software when an update is in progress, so that it waits before it touches a time or alarm register. When an alarm matches, a sticky flag is set. The interrupt output is high while that flag is set and the alarm interrupt is enabled.

Top module: `rtc_cal_core`

## Requirements
- R1: After reset every register reads 0x00 and `irq_o` is low.
- R2: An accepted tick adds one second in BCD. Seconds go from 0x59 to 0x00 and carry into minutes. Minutes go from 0x59 to 0x00 and carry into hours.
- R3: When hours go from 0x23 to 0x00, the day count rises by one. The day count goes from 0x7FFF back to 0x0000, so both day bytes read 0x00.
- R4: A tick has no effect while control bit 0 (calendar enable) is 0.
- R5: Control bit 7 (busy) reads 1 only in the cycle after an accepted tick. The new time becomes visible in the cycle after that, when busy reads 0 again.
- R6: A write issued while busy reads 1 is dropped, whatever register it addresses.
- R7: The register addresses are:
  - control 0x14
  - seconds 0x15
  - minutes 0x16
  - hours 0x17
  - day low byte 0x18
  - day high byte 0x19
  - alarm minute 0x1A
  - alarm hour 0x1B
  - alarm day low byte 0x1C
  - alarm day high byte 0x1D
  
  A write stores the data byte, except that a day high byte keeps only bits 6:0 and reads 0 in bit 7.
- R8: The alarm flag (control bit 2) is set when seconds go from 0x59 to 0x00 and every enabled field matches its alarm register after the increment. The field enables are control bit 3 for minute, bit 4 for hour and bit 5 for day.
- R9: With all three field enables clear, no match is declared.
- R10: The alarm flag is sticky. Writing 1 to bit 2 clears it, and writing 0 to bit 2 leaves it unchanged. Bits 0, 1, 3, 4 and 5 of the control register are stored as written. Bits 6 and 7 ignore writes.
- R11: `irq_o` equals the alarm flag ANDed with control bit 1 (alarm interrupt enable).
- R12: A write accepted on the same clock edge that captures a tick takes effect first. The increment then applies to the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second tick, one cycle wide |
| addr_i | input | 8 | Register byte address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; rdata_o is zero without it |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| irq_o | output | 1 | Level alarm interrupt |

## Verification
A register write and a tick can arrive on the same clock edge. The write is not held off on that edge, because busy only rises afterwards. The bench provokes this by driving a seconds write of 0x59 together with the tick. It then expects to read seconds 0x00 and a minute carry one cycle later. The same edge also carries a flag-clear write ahead of a second roll that re-sets the flag, and there the bench expects the flag to be set. Constrained random runs place the time a few seconds before a minute roll, with alarm values near the coming time, and compare every register and `irq_o` against a model in the bench.

// File: rtl/rtc_cal_core.sv
module rtc_cal_core #(
  parameter int ADDR_W = 8,
  parameter int DAY_W = 15,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  localparam int DHI_W = DAY_W - 8;
  localparam logic [ADDR_W-1:0] A_CTRL  = BASE_ADDR;
  localparam logic [ADDR_W-1:0] A_SEC   = BASE_ADDR + 1;
  localparam logic [ADDR_W-1:0] A_MIN   = BASE_ADDR + 2;
  localparam logic [ADDR_W-1:0] A_HR    = BASE_ADDR + 3;
  localparam logic [ADDR_W-1:0] A_DAYL  = BASE_ADDR + 4;
  localparam logic [ADDR_W-1:0] A_DAYH  = BASE_ADDR + 5;
  localparam logic [ADDR_W-1:0] A_AMIN  = BASE_ADDR + 6;
  localparam logic [ADDR_W-1:0] A_AHR   = BASE_ADDR + 7;
  localparam logic [ADDR_W-1:0] A_ADAYL = BASE_ADDR + 8;
  localparam logic [ADDR_W-1:0] A_ADAYH = BASE_ADDR + 9;
  localparam logic [7:0] SEC_LAST = 8'h59;
  localparam logic [7:0] MIN_LAST = 8'h59;
  localparam logic [7:0] HR_LAST  = 8'h23;

  logic [7:0] sec_q, min_q, hr_q, amin_q, ahr_q;
  logic [DAY_W-1:0] day_q, aday_q;
  logic cal_en_q, ie_q, flag_q, men_q, hen_q, den_q, busy_q;

  function automatic logic [7:0] bcd_step(input logic [7:0] v, input logic [7:0] last);
    if (v == last) return 8'h00;
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  logic sec_c, min_c, hr_c, any_en, hit, wr_ok;
  logic [7:0] min_nx, hr_nx;
  logic [DAY_W-1:0] day_nx;

  assign sec_c  = sec_q == SEC_LAST;
  assign min_c  = sec_c && min_q == MIN_LAST;
  assign hr_c   = min_c && hr_q == HR_LAST;
  assign min_nx = sec_c ? bcd_step(min_q, MIN_LAST) : min_q;
  assign hr_nx  = min_c ? bcd_step(hr_q, HR_LAST) : hr_q;
  assign day_nx = hr_c ? day_q + 1'b1 : day_q;
  assign any_en = men_q | hen_q | den_q;
  assign hit    = busy_q && sec_c && any_en &&
                  (!men_q || min_nx == amin_q) &&
                  (!hen_q || hr_nx == ahr_q) &&
                  (!den_q || day_nx == aday_q);
  assign wr_ok  = wr_i && !busy_q;
  assign irq_o  = flag_q & ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= '0; min_q <= '0; hr_q <= '0; day_q <= '0;
      amin_q <= '0; ahr_q <= '0; aday_q <= '0;
      cal_en_q <= 1'b0; ie_q <= 1'b0; flag_q <= 1'b0;
      men_q <= 1'b0; hen_q <= 1'b0; den_q <= 1'b0; busy_q <= 1'b0;
    end else begin
      busy_q <= tick_i && cal_en_q;
      if (busy_q) begin
        sec_q <= bcd_step(sec_q, SEC_LAST);
        min_q <= min_nx;
        hr_q  <= hr_nx;
        day_q <= day_nx;
        if (hit) flag_q <= 1'b1;
      end
      if (wr_ok) begin
        case (addr_i)
          A_CTRL: begin
            cal_en_q <= wdata_i[0];
            ie_q     <= wdata_i[1];
            if (wdata_i[2]) flag_q <= 1'b0;
            men_q    <= wdata_i[3];
            hen_q    <= wdata_i[4];
            den_q    <= wdata_i[5];
          end
          A_SEC:   sec_q <= wdata_i;
          A_MIN:   min_q <= wdata_i;
          A_HR:    hr_q  <= wdata_i;
          A_DAYL:  day_q[7:0] <= wdata_i;
          A_DAYH:  day_q[DAY_W-1:8] <= wdata_i[DHI_W-1:0];
          A_AMIN:  amin_q <= wdata_i;
          A_AHR:   ahr_q  <= wdata_i;
          A_ADAYL: aday_q[7:0] <= wdata_i;
          A_ADAYH: aday_q[DAY_W-1:8] <= wdata_i[DHI_W-1:0];
          default: ;
        endcase
      end
    end
  end

  logic [7:0] mux;
  always_comb begin
    case (addr_i)
      A_CTRL:  mux = {busy_q, 1'b0, den_q, hen_q, men_q, flag_q, ie_q, cal_en_q};
      A_SEC:   mux = sec_q;
      A_MIN:   mux = min_q;
      A_HR:    mux = hr_q;
      A_DAYL:  mux = day_q[7:0];
      A_DAYH:  mux = 8'(day_q[DAY_W-1:8]);
      A_AMIN:  mux = amin_q;
      A_AHR:   mux = ahr_q;
      A_ADAYL: mux = aday_q[7:0];
      A_ADAYH: mux = 8'(aday_q[DAY_W-1:8]);
      default: mux = 8'h00;
    endcase
  end
  assign rdata_o = rd_i ? mux : 8'h00;
endmodule

module rtc_cal_core_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              irq_o,
  input logic              busy,
  input logic              cal_en,
  input logic              flag,
  input logic [2:0]        fld_en,
  input logic [7:0]        sec,
  input logic [7:0]        amin
);
  localparam logic [ADDR_W-1:0] A_CTRL = BASE_ADDR;
  localparam logic [ADDR_W-1:0] A_AMIN = BASE_ADDR + 6;

  // R5
  busy_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $past(tick_i && cal_en));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_en && !busy && !wr_i) |=> $stable(sec));

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sec == 8'h59) |=> sec == 8'h00);

  // R6
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_i && addr_i == A_AMIN) |=> $stable(amin));

  // R9
  no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_en == 3'b000) |=> !$rose(flag));

  // R10
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_i && !busy && addr_i == A_CTRL && wdata_i[2])) |=> flag);

  // R11
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag);
endmodule

bind rtc_cal_core rtc_cal_core_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .busy(busy_q), .cal_en(cal_en_q),
  .flag(flag_q), .fld_en({den_q, hen_q, men_q}), .sec(sec_q), .amin(amin_q)
);

// File: tb/rtc_cal_core_test.sv
module rtc_cal_core_test;
  logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] addr_i = 8'h00, wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic irq_o;
  int checks = 0, fails = 0;

  rtc_cal_core uut (.clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i),
    .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o));

  always #2.5 clk = ~clk;

  int m_sec, m_min, m_hr, m_day, a_min, a_hr, a_day;
  bit m_en, m_ie, m_flag, m_men, m_hen, m_den;

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] ctrl_byte(input bit clr);
    return {2'b00, m_den, m_hen, m_men, clr, m_ie, m_en};
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr_i = a; rd_i = 1'b1; #0.5; v = rdata_o; rd_i = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic model_tick();
    if (!m_en) return;
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin m_hr = 0; m_day = (m_day + 1) % 32768; end
      end
      if ((m_men || m_hen || m_den) && (!m_men || m_min == a_min) &&
          (!m_hen || m_hr == a_hr) && (!m_den || m_day == a_day))
        m_flag = 1'b1;
    end
  endtask

  task automatic do_tick();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    @(negedge clk);
    model_tick();
  endtask

  task automatic load_time();
    wr(8'h15, bcd(m_sec)); wr(8'h16, bcd(m_min)); wr(8'h17, bcd(m_hr));
    wr(8'h18, 8'(m_day)); wr(8'h19, 8'(m_day >> 8));
  endtask

  task automatic load_alarm();
    wr(8'h1A, bcd(a_min)); wr(8'h1B, bcd(a_hr));
    wr(8'h1C, 8'(a_day)); wr(8'h1D, 8'(a_day >> 8));
  endtask

  task automatic compare_all(input string req);
    chk_reg(req, 8'h15, bcd(m_sec));
    chk_reg(req, 8'h16, bcd(m_min));
    chk_reg(req, 8'h17, bcd(m_hr));
    chk_reg(req, 8'h18, 8'(m_day));
    chk_reg(req, 8'h19, 8'(m_day >> 8));
    chk_reg(req, 8'h14, ctrl_byte(m_flag));
    chk(req, {7'd0, irq_o}, {7'd0, m_flag & m_ie});
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog got=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    {m_sec, m_min, m_hr, m_day, a_min, a_hr, a_day} = '0;
    {m_en, m_ie, m_flag, m_men, m_hen, m_den} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    for (int a = 8'h14; a <= 8'h1D; a++) chk_reg("R1 reset", 8'(a), 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);

    // R4
    m_sec = 10; wr(8'h15, bcd(m_sec));
    do_tick();
    chk_reg("R4 disabled", 8'h15, 8'h10);

    // R5
    m_en = 1'b1; wr(8'h14, ctrl_byte(1'b0));
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    chk_reg("R5 busy high", 8'h14, 8'h81);
    chk_reg("R5 old time", 8'h15, 8'h10);
    @(negedge clk); model_tick();
    chk_reg("R5 busy low", 8'h14, 8'h01);
    chk_reg("R5 new time", 8'h15, 8'h11);

    // R6
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0; addr_i = 8'h1A; wdata_i = 8'h33; wr_i = 1'b1;
    @(negedge clk); wr_i = 1'b0; model_tick();
    chk_reg("R6 dropped", 8'h1A, 8'h00);

    // R2 R3
    m_sec = 59; m_min = 59; m_hr = 23; m_day = 32767; load_time();
    do_tick();
    compare_all("R3 full wrap");

    // R7
    wr(8'h19, 8'hFF); chk_reg("R7 day hi", 8'h19, 8'h7F);
    wr(8'h1D, 8'hFF); chk_reg("R7 alarm day hi", 8'h1D, 8'h7F);
    wr(8'h1B, 8'h17); chk_reg("R7 alarm hr", 8'h1B, 8'h17);
    m_day = 32512;

    // R12
    @(negedge clk); tick_i = 1'b1; addr_i = 8'h15; wdata_i = 8'h59; wr_i = 1'b1;
    @(negedge clk); tick_i = 1'b0; wr_i = 1'b0;
    @(negedge clk);
    m_sec = 59; m_min = 0; m_hr = 0; model_tick();
    chk_reg("R12 sec", 8'h15, 8'h00);
    chk_reg("R12 min", 8'h16, 8'h01);

    // R8 R11 R10
    m_sec = 59; m_min = 9; m_hr = 3; m_day = 5; load_time();
    a_min = 10; a_hr = 4; a_day = 0; load_alarm();
    m_men = 1'b1; m_ie = 1'b1; wr(8'h14, ctrl_byte(1'b0));
    do_tick();
    chk_reg("R8 flag", 8'h14, 8'h0B | 8'h04);
    chk("R11 irq on", {7'd0, irq_o}, 8'h01);
    wr(8'h14, ctrl_byte(1'b0) | 8'hC0);
    chk_reg("R10 write 0 keeps, bits 7:6 ignored", 8'h14, 8'h0F);
    m_ie = 1'b0; wr(8'h14, ctrl_byte(1'b0));
    chk("R11 irq masked", {7'd0, irq_o}, 8'h00);
    chk_reg("R10 still set", 8'h14, 8'h0D);
    m_flag = 1'b0; wr(8'h14, ctrl_byte(1'b1));
    chk_reg("R10 cleared", 8'h14, 8'h09);

    // R12 R10: clear written on the tick edge, then a re-set
    m_sec = 59; m_min = 9; load_time(); m_flag = 1'b1;
    wr(8'h15, 8'h59); m_sec = 59;
    wr(8'h16, 8'h09);
    m_flag = 1'b0;
    do_tick();
    @(negedge clk); tick_i = 1'b0;
    m_sec = 59; m_min = 9; load_time();
    @(negedge clk); tick_i = 1'b1; addr_i = 8'h14; wdata_i = ctrl_byte(1'b1); wr_i = 1'b1;
    @(negedge clk); tick_i = 1'b0; wr_i = 1'b0;
    @(negedge clk); m_flag = 1'b0; model_tick();
    chk_reg("R12 clear then set", 8'h14, ctrl_byte(m_flag));

    // R9
    m_men = 1'b0; m_flag = 1'b0; wr(8'h14, ctrl_byte(1'b1));
    m_sec = 59; m_min = 9; load_time();
    do_tick();
    chk_reg("R9 no enables", 8'h14, 8'h01);

    // R2 R3 R8 random
    for (int i = 0; i < 40; i++) begin
      m_hr = $urandom % 24; m_min = $urandom % 60; m_sec = 55 + $urandom % 5;
      m_day = $urandom % 32768;
      if ($urandom % 3 == 0) begin m_min = 59; if ($urandom % 2 == 0) m_hr = 23; end
      if ($urandom % 4 == 0) m_day = 32767;
      load_time();
      a_min = ($urandom % 2) ? (m_min + 1) % 60 : $urandom % 60;
      a_hr  = ($urandom % 2) ? (m_min == 59 ? (m_hr + 1) % 24 : m_hr) : $urandom % 24;
      a_day = ($urandom % 2) ? m_day : $urandom % 32768;
      load_alarm();
      {m_den, m_hen, m_men} = 3'($urandom);
      m_ie = 1'($urandom); m_flag = 1'b0;
      wr(8'h14, ctrl_byte(1'b1));
      for (int t = m_sec; t < 60; t++) do_tick();
      compare_all("R8 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule